// File: doc/BRIEF.md
# EDID Block Reader for the Display Data Channel

This controller fetches a display's capability data, one 128-byte block at a time, through an external byte-level I2C master that has enhanced segment addressing. For each block it issues sixteen 8-byte burst read commands. Each command carries a slave address, a segment address, a segment pointer, a word offset and the choice between the plain and the segmented read opcode. Each returned burst is written into a 256-byte capture buffer. When block 0 shows that an extension block follows, the controller reads block 1 into the upper half of the buffer.

A burst that does not finish within a millisecond-based time limit makes the controller pulse a soft reset to the I2C master. It then abandons the block and restarts that block from its first burst. After a fixed number of failed attempts on a block, the operation ends with an error. The bit-level bus engine, the bus clock divider and the display itself are outside this block.

Top module: `edid_reader`

## Requirements
- R1: While reset is held and after it is released, `done`, `error`, `cmdValid`, `bufWe`, `doneClr` and `mstReset` are 0 and `byteCount` is 0.
- R2: A block is read as 16 bursts of 8 bytes, in order, with burst n at word offset base + 8·n. The first command appears in the cycle after `start` is sampled. Each later command appears in the cycle after the previous burst's done flag is accepted. `cmdValid` is a single-cycle pulse.
- R3: The segment pointer is the block number shifted right by one, so it is 0 for blocks 0 and 1. The base offset is 0x80 for an odd block and 0 for an even block, which makes `cmdOffset[7]` the block's low bit. Block 0 uses the plain read (`cmdExt`=0) and block 1 uses the segmented read (`cmdExt`=1).
- R4: Each accepted burst gives one `bufWe` cycle. In that cycle `bufAddr` = block·128 + 8·n and `bufData` = `burstData`. Byte i of a burst, the byte at word offset + i, sits in bits [8i+7:8i].
- R5: `doneClr` is high in exactly the cycle in which a raised `burstDone` is accepted, which comes before the next command.
- R6: Byte 0x7E of block 0 is byte 6 of burst 15. If that byte is nonzero, block 1 is read next, and the operation then ends with `done`=1 and `byteCount`=256. If it is zero, the operation ends after block 0 with `byteCount`=128.
- R7: If 10 `msTick` pulses are sampled while a burst waits without `burstDone`, `mstReset` pulses for one cycle on the tenth pulse. The next command restarts the same block at burst 0.
- R8: A block may be attempted at most 5 times. The fifth timeout on a block ends the operation with `done`=1 and `error`=1. In that case `byteCount` is 128 times the number of blocks already completed: 0 if block 0 failed, 128 if block 1 failed.
- R9: If `burstDone` and the tenth `msTick` fall in the same cycle, the burst is accepted and no reset or restart occurs.
- R10: A `start` pulse while an operation is in progress has no effect. The read continues in order and ends with the same result.
- R11: `cmdSlave` is 0x50 and `cmdSegAddr` is 0x30 on every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read; sampled only when idle |
| burstDone | input | 1 | Burst-complete flag from the I2C master, held until cleared |
| burstData | input | 64 | The eight bytes of the finished burst |
| msTick | input | 1 | One-cycle pulse per millisecond |
| cmdValid | output | 1 | Burst command strobe |
| cmdExt | output | 1 | 1 = segmented 8-byte read, 0 = plain 8-byte read |
| cmdSlave | output | 7 | DDC slave address |
| cmdSegAddr | output | 7 | DDC segment address |
| cmdSegPtr | output | 7 | Segment pointer (block number >> 1) |
| cmdOffset | output | 8 | Word offset of the burst |
| doneClr | output | 1 | Clears the master's burst-complete flag |
| mstReset | output | 1 | Soft reset pulse to the I2C master |
| bufWe | output | 1 | Capture-buffer write strobe, 8 bytes wide |
| bufAddr | output | 8 | Buffer byte address of the write |
| bufData | output | 64 | Buffer write data |
| byteCount | output | 9 | Bytes of valid data when finished |
| done | output | 1 | Operation finished; held until the next start |
| error | output | 1 | Operation ended by exhausted retries; held with done |

## Verification
Burst acceptance and the timeout path can both be triggered in the same cycle: the last millisecond tick of a burst's time limit can coincide with that burst's done flag. The bench drives both inputs by hand for this case. It gives nine ticks to bring the wait to its limit, then raises the tenth tick and `burstDone` in the same cycle. It then requires a buffer write with no master reset, followed by a command for the next burst rather than a restart at burst 0. The same hand-driven setup then lets a later burst run out its time limit alone, which shows that the reset pulse and the restart occur when no done flag competes with the tick.

// File: rtl/edid_rd_pkg.sv
package edid_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic clrTick;
    logic incTick;
    logic accept;
    logic incBurst;
    logic clrBurst;
    logic incTry;
    logic clrTry;
    logic nextBlock;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic tickLast;
    logic burstLast;
    logic tryLast;
    logic onBlock0;
    logic extFlag;
  } dpStat_t;

endpackage

// File: rtl/edid_rd_dp.sv
module edid_rd_dp
  import edid_rd_pkg::*;
#(
  parameter int BURSTS      = 16,
  parameter int BURST_BYTES = 8,
  parameter int TIMEOUT_MS  = 10,
  parameter int MAX_TRIES   = 5,
  parameter int EXT_BYTE    = 126,
  localparam int BURST_W    = $clog2(BURSTS),
  localparam int SHIFT      = $clog2(BURST_BYTES),
  localparam int ADDR_W     = 1 + BURST_W + SHIFT,
  localparam int DATA_W     = 8 * BURST_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  input  logic [DATA_W-1:0] burstData,
  output logic              cmdExt,
  output logic [6:0]        cmdSegPtr,
  output logic [ADDR_W-1:0] cmdOffset,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [DATA_W-1:0] bufData
);
  localparam int TICK_W    = $clog2(TIMEOUT_MS + 1);
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam int EXT_LANE  = EXT_BYTE % BURST_BYTES;
  localparam int EXT_BURST = EXT_BYTE / BURST_BYTES;

  logic [7:0]         blockIdx;
  logic [BURST_W-1:0] burstIdx;
  logic [TICK_W-1:0]  tickCnt;
  logic [TRY_W-1:0]   tryCnt;
  logic               extSeen;
  logic               laneNz;
  logic               atExtBurst;

  assign laneNz     = burstData[EXT_LANE*8 +: 8] != 8'd0;
  assign atExtBurst = burstIdx == BURST_W'(EXT_BURST);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      blockIdx <= '0;
      burstIdx <= '0;
      tickCnt  <= '0;
      tryCnt   <= '0;
      extSeen  <= 1'b0;
    end else begin
      if (ctl.clrTick)       tickCnt <= '0;
      else if (ctl.incTick)  tickCnt <= tickCnt + TICK_W'(1);
      if (ctl.clrBurst)      burstIdx <= '0;
      else if (ctl.incBurst) burstIdx <= burstIdx + BURST_W'(1);
      if (ctl.clrTry)        tryCnt <= '0;
      else if (ctl.incTry)   tryCnt <= tryCnt + TRY_W'(1);
      if (ctl.nextBlock)     blockIdx <= blockIdx + 8'd1;
      if (ctl.accept && blockIdx == 8'd0 && atExtBurst) extSeen <= laneNz;
    end
  end

  assign stat.tickLast  = tickCnt == TICK_W'(TIMEOUT_MS - 1);
  assign stat.burstLast = burstIdx == BURST_W'(BURSTS - 1);
  assign stat.tryLast   = tryCnt == TRY_W'(MAX_TRIES - 1);
  assign stat.onBlock0  = blockIdx == 8'd0;
  assign stat.extFlag   = atExtBurst ? laneNz : extSeen;

  assign cmdExt    = blockIdx != 8'd0;
  assign cmdSegPtr = blockIdx[7:1];
  assign cmdOffset = {blockIdx[0], burstIdx, SHIFT'(0)};
  assign bufAddr   = cmdOffset;
  assign bufData   = burstData;

  // R7
  tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < TICK_W'(TIMEOUT_MS));
  // R8
  try_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < TRY_W'(MAX_TRIES));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrBurst && !ctl.nextBlock && !ctl.accept) |=> burstIdx == '0);

endmodule

// File: rtl/edid_rd_ctl.sv
module edid_rd_ctl
  import edid_rd_pkg::*;
#(
  parameter int BLOCK_BYTES = 128,
  localparam int CNT_W      = $clog2(2 * BLOCK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             burstDone,
  input  logic             msTick,
  input  dpStat_t          stat,
  output dpCtl_t           ctl,
  output logic             cmdValid,
  output logic             doneClr,
  output logic             mstReset,
  output logic             bufWe,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] byteCount
);
  rdState_e state, nxt;
  logic finOk, finErr;

  always_comb begin
    ctl      = '0;
    nxt      = state;
    cmdValid = 1'b0;
    doneClr  = 1'b0;
    mstReset = 1'b0;
    bufWe    = 1'b0;
    finOk    = 1'b0;
    finErr   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          nxt        = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmdValid    = 1'b1;
        ctl.clrTick = 1'b1;
        nxt         = ST_WAIT;
      end
      ST_WAIT: begin
        if (burstDone) begin
          bufWe      = 1'b1;
          doneClr    = 1'b1;
          ctl.accept = 1'b1;
          if (stat.burstLast) begin
            ctl.clrBurst = 1'b1;
            if (stat.onBlock0 && stat.extFlag) begin
              ctl.nextBlock = 1'b1;
              ctl.clrTry    = 1'b1;
              nxt           = ST_ISSUE;
            end else begin
              finOk = 1'b1;
              nxt   = ST_IDLE;
            end
          end else begin
            ctl.incBurst = 1'b1;
            nxt          = ST_ISSUE;
          end
        end else if (msTick) begin
          if (stat.tickLast) begin
            mstReset     = 1'b1;
            ctl.clrBurst = 1'b1;
            if (stat.tryLast) begin
              finErr = 1'b1;
              nxt    = ST_IDLE;
            end else begin
              ctl.incTry = 1'b1;
              nxt        = ST_ISSUE;
            end
          end else begin
            ctl.incTick = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      error     <= 1'b0;
      byteCount <= '0;
    end else begin
      state <= nxt;
      if (ctl.clrAll) begin
        done      <= 1'b0;
        error     <= 1'b0;
        byteCount <= '0;
      end else if (finOk) begin
        done      <= 1'b1;
        byteCount <= stat.onBlock0 ? CNT_W'(BLOCK_BYTES) : CNT_W'(2 * BLOCK_BYTES);
      end else if (finErr) begin
        done      <= 1'b1;
        error     <= 1'b1;
        byteCount <= stat.onBlock0 ? CNT_W'(0) : CNT_W'(BLOCK_BYTES);
      end
    end
  end

  // R7
  reset_then_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    mstReset |=> (cmdValid || (done && error)));
  // R2
  write_then_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |=> (cmdValid || (done && !error)));
  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  // R6
  ok_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && !error) |-> (byteCount == CNT_W'(BLOCK_BYTES) ||
                                 byteCount == CNT_W'(2 * BLOCK_BYTES)));
  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
  // R9
  done_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> !mstReset);

endmodule

// File: rtl/edid_reader.sv
module edid_reader
  import edid_rd_pkg::*;
#(
  parameter int         BURSTS      = 16,
  parameter int         BURST_BYTES = 8,
  parameter int         TIMEOUT_MS  = 10,
  parameter int         MAX_TRIES   = 5,
  parameter int         EXT_BYTE    = 126,
  parameter logic [6:0] DDC_SLAVE   = 7'h50,
  parameter logic [6:0] DDC_SEG     = 7'h30,
  localparam int ADDR_W      = 1 + $clog2(BURSTS) + $clog2(BURST_BYTES),
  localparam int DATA_W      = 8 * BURST_BYTES,
  localparam int BLOCK_BYTES = BURSTS * BURST_BYTES,
  localparam int CNT_W       = $clog2(2 * BLOCK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              burstDone,
  input  logic [DATA_W-1:0] burstData,
  input  logic              msTick,
  output logic              cmdValid,
  output logic              cmdExt,
  output logic [6:0]        cmdSlave,
  output logic [6:0]        cmdSegAddr,
  output logic [6:0]        cmdSegPtr,
  output logic [ADDR_W-1:0] cmdOffset,
  output logic              doneClr,
  output logic              mstReset,
  output logic              bufWe,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [DATA_W-1:0] bufData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              done,
  output logic              error
);
  dpCtl_t  ctl;
  dpStat_t stat;

  assign cmdSlave   = DDC_SLAVE;
  assign cmdSegAddr = DDC_SEG;

  edid_rd_ctl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .burstDone(burstDone),
    .msTick(msTick), .stat(stat), .ctl(ctl), .cmdValid(cmdValid),
    .doneClr(doneClr), .mstReset(mstReset), .bufWe(bufWe),
    .done(done), .error(error), .byteCount(byteCount)
  );

  edid_rd_dp #(
    .BURSTS(BURSTS), .BURST_BYTES(BURST_BYTES), .TIMEOUT_MS(TIMEOUT_MS),
    .MAX_TRIES(MAX_TRIES), .EXT_BYTE(EXT_BYTE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat), .burstData(burstData),
    .cmdExt(cmdExt), .cmdSegPtr(cmdSegPtr), .cmdOffset(cmdOffset),
    .bufAddr(bufAddr), .bufData(bufData)
  );

endmodule

// File: tb/edid_reader_bench.sv
`timescale 1ns/1ps
module edid_reader_bench;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic        burstDone = 1'b0, msTick = 1'b0;
  logic [63:0] burstData = '0;
  logic        cmdValid, cmdExt, doneClr, mstReset, bufWe, done, error;
  logic [6:0]  cmdSlave, cmdSegAddr, cmdSegPtr;
  logic [7:0]  cmdOffset, bufAddr;
  logic [63:0] bufData;
  logic [8:0]  byteCount;

  edid_reader u_edid_reader (
    .clk(clk), .rstN(rstN), .start(start), .burstDone(burstDone),
    .burstData(burstData), .msTick(msTick), .cmdValid(cmdValid),
    .cmdExt(cmdExt), .cmdSlave(cmdSlave), .cmdSegAddr(cmdSegAddr),
    .cmdSegPtr(cmdSegPtr), .cmdOffset(cmdOffset), .doneClr(doneClr),
    .mstReset(mstReset), .bufWe(bufWe), .bufAddr(bufAddr),
    .bufData(bufData), .byteCount(byteCount), .done(done), .error(error)
  );

  initial forever #2 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input int a, input logic [7:0] ext);
    return (a == 126) ? ext : 8'((a * 7 + 3) & 255);
  endfunction

  typedef struct packed {
    logic [7:0] ext;
    logic [4:0] failIdx;
    logic [3:0] failCnt;
    logic [3:0] lat;
    logic [8:0] expCount;
    logic       expErr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h00, 5'd0,  4'd0, 4'd0, 9'd128, 1'b0},
    '{8'h01, 5'd0,  4'd0, 4'd2, 9'd256, 1'b0},
    '{8'h80, 5'd3,  4'd2, 4'd1, 9'd256, 1'b0},
    '{8'h00, 5'd15, 4'd4, 4'd0, 9'd128, 1'b0},
    '{8'h00, 5'd5,  4'd5, 4'd1, 9'd0,   1'b1},
    '{8'h02, 5'd16, 4'd5, 4'd0, 9'd128, 1'b1},
    '{8'h05, 5'd25, 4'd1, 4'd3, 9'd256, 1'b0}
  };

  // responder state
  bit         respOn = 1'b1, autoTick = 1'b1, pendClr = 1'b0;
  logic [7:0] curExt = '0, lastOff = '0;
  int         failIdx = 0, stallLeft = 0, lat = 0, pend = -1;
  int         resets = 0, writeIdx = 0, cyc = 0;
  logic [7:0] cap [256];

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (autoTick) msTick = (cyc % 5 == 0);
      if (respOn) begin
        if (pendClr) burstDone = 1'b0;
        pendClr = 1'b0;
        if (cmdValid) begin
          chk(cmdExt == cmdOffset[7], "R3", "cmdExt vs block", cmdExt, cmdOffset[7]);
          chk(cmdSegPtr == 7'd0, "R3", "segment pointer", cmdSegPtr, 0);
          chk(cmdSlave == 7'h50 && cmdSegAddr == 7'h30, "R11", "addresses",
              {cmdSlave, cmdSegAddr}, {7'h50, 7'h30});
          if (int'({cmdOffset[7], cmdOffset[6:3]}) == failIdx && stallLeft > 0) begin
            stallLeft--;
            pend = -1;
          end else begin
            pend    = lat;
            lastOff = cmdOffset;
          end
        end else if (pend > 0) begin
          pend--;
        end else if (pend == 0) begin
          for (int k = 0; k < 8; k++) burstData[8*k +: 8] = model(int'(lastOff) + k, curExt);
          burstDone = 1'b1;
          pend = -1;
        end
      end
      #1;
      if (respOn && doneClr) pendClr = 1'b1;
      if (mstReset) begin
        resets++;
        writeIdx = (writeIdx / 16) * 16;
      end
      if (bufWe) begin
        logic [63:0] expData;
        chk(doneClr == 1'b1, "R5", "doneClr with write", doneClr, 1);
        chk(int'(bufAddr) == writeIdx * 8, "R4", "write address order", bufAddr, writeIdx * 8);
        for (int k = 0; k < 8; k++) expData[8*k +: 8] = model(int'(bufAddr) + k, curExt);
        chk(bufData == expData, "R4", "write data", bufData, expData);
        for (int k = 0; k < 8; k++) cap[int'(bufAddr) + k] = bufData[8*k +: 8];
        writeIdx++;
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic checkResult(input string req, input int expCount, input bit expErr,
                             input int expResets, input logic [7:0] ext);
    int bad = 0;
    chk(done == 1'b1, req, "done", done, 1);
    chk(error == expErr, req, "error", error, expErr);
    chk(int'(byteCount) == expCount, req, "byteCount", byteCount, expCount);
    chk(resets == expResets, "R7", "reset pulses", resets, expResets);
    for (int a = 0; a < expCount; a++) if (cap[a] !== model(a, ext)) bad++;
    chk(bad == 0, "R4", "buffer contents mismatches", bad, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) cap[a] = 8'hxx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !error && !cmdValid && !bufWe && !doneClr && !mstReset && byteCount == 0,
        "R1", "outputs in reset", {done, error, cmdValid, bufWe, byteCount}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !error && !cmdValid && byteCount == 0, "R1", "outputs after reset",
        {done, error, cmdValid, byteCount}, 0);

    // table-driven runs
    for (int v = 0; v < 7; v++) begin
      curExt = VECS[v].ext; failIdx = int'(VECS[v].failIdx);
      stallLeft = int'(VECS[v].failCnt); lat = int'(VECS[v].lat);
      resets = 0; writeIdx = 0;
      for (int a = 0; a < 256; a++) cap[a] = 8'hxx;
      pulseStart();
      chk(cmdValid == 1'b1 && cmdOffset == 8'h00, "R2", "first command timing",
          {cmdValid, cmdOffset}, {1'b1, 8'h00});
      waitDone();
      checkResult(VECS[v].expErr ? "R8" : "R6", int'(VECS[v].expCount),
                  VECS[v].expErr, int'(VECS[v].failCnt), VECS[v].ext);
    end

    // R9 done and final tick together, then R7 timeout alone
    respOn = 1'b0; autoTick = 1'b0; msTick = 1'b0; burstDone = 1'b0; pendClr = 1'b0;
    curExt = 8'h00; resets = 0; writeIdx = 0;
    pulseStart();
    chk(cmdValid && cmdOffset == 8'h00, "R2", "manual first command", cmdOffset, 0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
    @(negedge clk);
    msTick = 1'b1; burstDone = 1'b1;
    for (int k = 0; k < 8; k++) burstData[8*k +: 8] = model(k, 8'h00);
    #1;
    chk(bufWe && !mstReset, "R9", "done beats tick", {bufWe, mstReset}, 2'b10);
    @(negedge clk);
    msTick = 1'b0; burstDone = 1'b0;
    chk(cmdValid && cmdOffset == 8'h08, "R9", "next burst issued", cmdOffset, 8'h08);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
    @(negedge clk); msTick = 1'b1;
    #1;
    chk(mstReset == 1'b1, "R7", "reset on tenth tick", mstReset, 1);
    lat = 1; failIdx = 0; stallLeft = 0; pend = -1;
    respOn = 1'b1; autoTick = 1'b1;
    @(negedge clk);
    chk(cmdValid && cmdOffset == 8'h00, "R7", "restart at burst 0", cmdOffset, 0);
    waitDone();
    checkResult("R7", 128, 1'b0, 1, 8'h00);

    // R10 start while busy is ignored
    curExt = 8'h01; lat = 2; resets = 0; writeIdx = 0;
    for (int a = 0; a < 256; a++) cap[a] = 8'hxx;
    pulseStart();
    repeat (40) @(negedge clk);
    chk(done == 1'b0, "R10", "busy before second start", done, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone();
    checkResult("R10", 256, 1'b0, 0, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule